// File: doc/BRIEF.md
# Host-to-Board Command Mailbox Controller

This block sits between a host register bus and the controller of an add-on memory board. The host fills four 16-bit registers (command, offset, parameter-low, parameter-high) and then rings a doorbell through a fifth register, the status register. The board side takes the command apart into a group and an opcode. It answers system commands on its own. It turns away every other group with a failure reply. Whenever it puts something in the registers for the host, it raises a level interrupt.

A startup command from the host loads a fixed set-base-address request and arms a poll timer. From then on, the board uses the same four registers to issue a read request ("peek") of a fixed address once per poll period. The same interrupt announces each peek. A period is dropped when the host has not yet acknowledged the previous interrupt.

The controller is a five-state machine:

- `S_IDLE` waits for a doorbell or a due poll.
- `S_DECODE` classifies the command.
- `S_FAIL` writes a failure reply.
- `S_BOOT` writes the startup reply and arms the timer.
- `S_PEEK` writes a peek request.

Transitions:

- **idle→decode:** a doorbell arrives, or one is held over.
- **idle→peek:** a poll is due and no interrupt is pending.
- **decode→fail:** the group is non-zero.
- **decode→boot:** the opcode is startup (0xF) in group 0.
- **decode→idle:** any other system opcode.
- **fail→idle and boot→idle:** taken once the interrupt is free; the state waits while it is pending.
- **peek→idle:** taken unconditionally.

Top module: `mbox_ctrl`

## Requirements
- R1: After reset the four data registers read 0, the interrupt output is low and the status register reads 0x0111.
- R2: A host write to address 0 (command), 1 (offset), 2 (parameter-low) or 3 (parameter-high) is read back unchanged at the same address when no board event intervenes.
- R3: Address 4 (status) reads 0x0111 while no interrupt is pending and 0x0011 while one is pending.
- R4: A status write with bit 8 set clears a pending interrupt. A status write with bit 8 clear leaves the interrupt as it was.
- R5: A status write with bit 0 clear is a doorbell that starts decoding of the command register. A status write with bit 0 set starts nothing, so the registers and the interrupt stay unchanged.
- R6: On a doorbell, the command group is read from bits 14:13. A non-zero group produces a failure reply within three cycles of the doorbell write. The reply sets command to ((command & 0x7E00) + 0x0400) | 0x00FF, offset to 0 and both parameter registers to 0xFFFF, and raises the interrupt.
- R7: A group-0 command whose opcode (bits 12:9) is anything but 0xF changes no register and raises no interrupt.
- R8: The group-0 startup opcode 0xF sets command 0x8600, offset 0, parameter-high 0x0C00 and parameter-low 0, raises the interrupt and starts the poll timer.
- R9: Once started, the block raises a peek every POLL_CYCLES cycles (the first one POLL_CYCLES+2 cycles after the startup interrupt). A peek sets command to 0x8000 | size_code<<9 | addr[24:16], offset to addr[15:0] and both parameters to 0. The size code is 4 for 1 byte, 5 for 2 bytes and 6 for 4 bytes.
- R10: A poll period that expires while the interrupt is pending issues no peek. The next peek stays on the original period grid.
- R11: A failure or startup reply due while the interrupt is pending is held, leaving the registers as they were. It is written as soon as the host clears the interrupt.
- R12: The interrupt is never raised by the board while it is already pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 3 | Register address (0 cmd, 1 offset, 2 param-low, 3 param-high, 4 status) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for host_addr (combinational) |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
Doorbells are rung with random commands from every group. This separates the failure path (groups 1 to 3) from silent callbacks (group 0, opcodes other than 0xF), and a wrong field position or reply arithmetic shows up as a mismatched register. Status writes with each combination of bits 0 and 8 show whether clearing and doorbell are decoded from the right bits. After startup, the cycle distance between peeks shows whether the period is exact. Leaving the interrupt pending across two periods, and ringing a failing doorbell on top of a pending peek, separates skipped polls from held replies.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int REG_W = 16;

    localparam logic [2:0] A_CMD  = 3'd0;
    localparam logic [2:0] A_OFF  = 3'd1;
    localparam logic [2:0] A_PARL = 3'd2;
    localparam logic [2:0] A_PARH = 3'd3;
    localparam logic [2:0] A_STAT = 3'd4;

    localparam logic [15:0] STAT_FREE = 16'h0111;
    localparam logic [15:0] STAT_BUSY = 16'h0011;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DECODE,
        S_FAIL,
        S_BOOT,
        S_PEEK
    } mbox_state_e;

    typedef struct packed {
        logic             en;
        logic [15:0]      cmd;
        logic [15:0]      off;
        logic [15:0]      parl;
        logic [15:0]      parh;
    } mbox_load_t;

    // reply: keep bits 14:9, step by 0x400, low byte carries the verdict
    function automatic logic [15:0] reply_word(input logic [15:0] cmd, input logic fail);
        logic [15:0] t;
        t = (cmd & 16'h7E00) + 16'h0400;
        return t | (fail ? 16'h00FF : 16'h0004);
    endfunction

    function automatic logic [2:0] size_code(input int nbytes);
        return (nbytes == 1) ? 3'd4 : (nbytes == 2) ? 3'd5 : 3'd6;
    endfunction

    function automatic logic [15:0] peek_word(input logic [31:0] addr, input logic [2:0] code);
        return 16'h8000 | {4'd0, code, addr[24:16]};
    endfunction

endpackage

// File: rtl/mbox_regfile.sv
module mbox_regfile
    import mbox_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [2:0]  host_addr,
    input  logic [15:0] host_wdata,
    input  mbox_load_t  ld,
    input  logic        irq_set,
    output logic [15:0] cmd_q,
    output logic [15:0] off_q,
    output logic [15:0] parl_q,
    output logic [15:0] parh_q,
    output logic        irq_q,
    output logic        bell,
    output logic [15:0] rdata
);

    logic stat_wr;
    assign stat_wr = host_we && (host_addr == A_STAT);
    assign bell    = stat_wr && !host_wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            off_q  <= '0;
            parl_q <= '0;
            parh_q <= '0;
        end else if (ld.en) begin
            cmd_q  <= ld.cmd;
            off_q  <= ld.off;
            parl_q <= ld.parl;
            parh_q <= ld.parh;
        end else if (host_we) begin
            unique case (host_addr)
                A_CMD:   cmd_q  <= host_wdata;
                A_OFF:   off_q  <= host_wdata;
                A_PARL:  parl_q <= host_wdata;
                A_PARH:  parh_q <= host_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (irq_set)
            irq_q <= 1'b1;
        else if (stat_wr && host_wdata[8])
            irq_q <= 1'b0;
    end

    always_comb begin
        unique case (host_addr)
            A_CMD:   rdata = cmd_q;
            A_OFF:   rdata = off_q;
            A_PARL:  rdata = parl_q;
            A_PARH:  rdata = parh_q;
            A_STAT:  rdata = irq_q ? STAT_BUSY : STAT_FREE;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
    parameter int POLL_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic irq_busy,
    input  logic taken,
    output logic due
);

    localparam int CNT_W = (POLL_CYCLES > 2) ? $clog2(POLL_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(POLL_CYCLES - 1);

    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;
    logic             expire;

    assign expire = armed_q && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (arm) begin
            armed_q <= 1'b1;
            cnt_q   <= '0;
        end else if (armed_q) begin
            cnt_q <= expire ? '0 : cnt_q + 1'b1;
        end
    end

    // a period expiring under a pending interrupt is dropped
    always_ff @(posedge clk) begin
        if (!rst_n || arm)
            due <= 1'b0;
        else if (expire && !irq_busy)
            due <= 1'b1;
        else if (taken)
            due <= 1'b0;
    end

endmodule

// File: rtl/mbox_fsm.sv
module mbox_fsm
    import mbox_pkg::*;
#(
    parameter logic [15:0] BOOT_CMD  = 16'h8600,
    parameter logic [15:0] BOOT_PARH = 16'h0C00,
    parameter logic [15:0] PEEK_CMD  = 16'h8C01,
    parameter logic [15:0] PEEK_OFF  = 16'hFC08
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bell,
    input  logic [15:0] cmd_q,
    input  logic        irq_q,
    input  logic        due,
    output mbox_load_t  ld,
    output logic        irq_set,
    output logic        arm,
    output logic        taken
);

    mbox_state_e state_q, state_d;
    logic        hold_q;
    logic [1:0]  grp;
    logic [3:0]  opc;

    assign grp = cmd_q[14:13];
    assign opc = cmd_q[12:9];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            hold_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && (bell || hold_q))
                hold_q <= 1'b0;
            else if (bell)
                hold_q <= 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (bell || hold_q)
                    state_d = S_DECODE;
                else if (due && !irq_q)
                    state_d = S_PEEK;
            end
            S_DECODE: begin
                if (grp != 2'd0)
                    state_d = S_FAIL;
                else if (opc == 4'hF)
                    state_d = S_BOOT;
                else
                    state_d = S_IDLE;
            end
            S_FAIL:  if (!irq_q) state_d = S_IDLE;
            S_BOOT:  if (!irq_q) state_d = S_IDLE;
            S_PEEK:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        ld      = '0;
        irq_set = 1'b0;
        arm     = 1'b0;
        taken   = 1'b0;
        unique case (state_q)
            S_FAIL: if (!irq_q) begin
                ld.en   = 1'b1;
                ld.cmd  = reply_word(cmd_q, 1'b1);
                ld.off  = 16'h0000;
                ld.parl = 16'hFFFF;
                ld.parh = 16'hFFFF;
                irq_set = 1'b1;
            end
            S_BOOT: if (!irq_q) begin
                ld.en   = 1'b1;
                ld.cmd  = BOOT_CMD;
                ld.parh = BOOT_PARH;
                irq_set = 1'b1;
                arm     = 1'b1;
            end
            S_PEEK: begin
                ld.en   = 1'b1;
                ld.cmd  = PEEK_CMD;
                ld.off  = PEEK_OFF;
                irq_set = 1'b1;
                taken   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
    import mbox_pkg::*;
#(
    parameter int          POLL_CYCLES = 1000,
    parameter logic [31:0] POLL_ADDR   = 32'h0C01FC08,
    parameter int          POLL_BYTES  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [2:0]  host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        irq_o
);

    localparam logic [2:0]  PEEK_CODE = size_code(POLL_BYTES);
    localparam logic [15:0] PEEK_CMD  = peek_word(POLL_ADDR, PEEK_CODE);
    localparam logic [15:0] PEEK_OFF  = POLL_ADDR[15:0];

    mbox_load_t  ld;
    logic        irq_set, arm, taken, due, bell;
    logic [15:0] cmd_q, off_q, parl_q, parh_q;

    mbox_regfile u_regs (
        .clk, .rst_n, .host_we, .host_addr, .host_wdata,
        .ld, .irq_set,
        .cmd_q, .off_q, .parl_q, .parh_q,
        .irq_q(irq_o), .bell, .rdata(host_rdata)
    );

    mbox_fsm #(
        .BOOT_CMD (16'h8600),
        .BOOT_PARH(16'h0C00),
        .PEEK_CMD (PEEK_CMD),
        .PEEK_OFF (PEEK_OFF)
    ) u_fsm (
        .clk, .rst_n, .bell, .cmd_q, .irq_q(irq_o), .due,
        .ld, .irq_set, .arm, .taken
    );

    mbox_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_timer (
        .clk, .rst_n, .arm, .irq_busy(irq_o), .taken, .due
    );

endmodule

// File: rtl/mbox_ctrl_chk.sv
module mbox_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_we,
    input logic [2:0]  host_addr,
    input logic [15:0] host_wdata,
    input logic [15:0] host_rdata,
    input logic        irq_o,
    input logic        irq_set,
    input logic [15:0] cmd_q,
    input logic [15:0] off_q,
    input logic [15:0] parl_q,
    input logic [15:0] parh_q
);

    // R12
    a_r12_no_raise_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |-> !irq_o);

    // R4
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == 3'd4 && host_wdata[8] && !irq_set) |=> !irq_o);

    a_r4_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == 3'd4 && !host_wdata[8] && irq_o) |=> irq_o);

    // R3
    a_r3_status: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == 3'd4) |-> (host_rdata == (irq_o ? 16'h0011 : 16'h0111)));

    // R6
    a_r6_fail_fields: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_o) && cmd_q[7:0] == 8'hFF) |->
        (off_q == 16'h0 && parl_q == 16'hFFFF && parh_q == 16'hFFFF));

    // R9
    a_r9_peek_params: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_o) && cmd_q[15] && cmd_q[14:12] == 3'd0 && cmd_q[11:9] >= 3'd4) |->
        (parl_q == 16'h0 && parh_q == 16'h0));

endmodule

bind mbox_ctrl mbox_ctrl_chk u_chk (.*);

// File: tb/mbox_ctrl_bench.sv
module mbox_ctrl_bench;

    localparam int          P     = 64;
    localparam logic [31:0] PADDR = 32'h0155ABCD;
    localparam int          PBYT  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    mbox_ctrl #(.POLL_CYCLES(P), .POLL_ADDR(PADDR), .POLL_BYTES(PBYT)) u_mbox_ctrl (
        .clk, .rst_n, .host_we, .host_addr, .host_wdata, .host_rdata, .irq_o
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] exp_fail(input logic [15:0] c);
        return ((c & 16'h7E00) + 16'h0400) | 16'h00FF;
    endfunction

    function automatic logic [15:0] exp_peek();
        logic [2:0] code;
        code = (PBYT == 1) ? 3'd4 : (PBYT == 2) ? 3'd5 : 3'd6;
        return 16'h8000 | (16'(code) << 9) | 16'(PADDR[24:16]);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        host_addr = a;
        #1 v = host_rdata;
    endtask

    task automatic chk_regs(input string req, input logic [15:0] c, input logic [15:0] o,
                            input logic [15:0] pl, input logic [15:0] ph, input logic irq);
        logic [15:0] v;
        rd(3'd0, v); chk({req, " cmd"}, v, c);
        rd(3'd1, v); chk({req, " off"}, v, o);
        rd(3'd2, v); chk({req, " parl"}, v, pl);
        rd(3'd3, v); chk({req, " parh"}, v, ph);
        chk({req, " irq"}, {15'd0, irq_o}, {15'd0, irq});
    endtask

    task automatic wait_irq(input int maxc, output int t, output bit ok);
        ok = 1'b0;
        t = 0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (irq_o) begin
                ok = 1'b1;
                t = cyc;
                break;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, c, o, pl, ph;
        int t_boot, t1, t2, t3;
        bit ok;
        void'($urandom(32'd4711));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_regs("R1", 16'h0, 16'h0, 16'h0, 16'h0, 1'b0);
        rd(3'd4, v); chk("R1 status", v, 16'h0111);

        // R2 readback
        wr(3'd0, 16'h1234); wr(3'd1, 16'hBEEF); wr(3'd2, 16'h0F0F); wr(3'd3, 16'hA5A5);
        chk_regs("R2", 16'h1234, 16'hBEEF, 16'h0F0F, 16'hA5A5, 1'b0);

        // R5 status write with bit0 set: no doorbell
        wr(3'd0, 16'h2000);
        wr(3'd4, 16'h0001);
        repeat (5) @(negedge clk);
        chk_regs("R5 no-bell", 16'h2000, 16'hBEEF, 16'h0F0F, 16'hA5A5, 1'b0);

        // R6/R7 random + directed commands
        for (int i = 0; i < 40; i++) begin
            c = 16'($urandom); o = 16'($urandom); pl = 16'($urandom); ph = 16'($urandom);
            if (i < 4) c[14:13] = 2'(i);
            if (i >= 4 && i < 15) begin c[14:13] = 2'd0; c[12:9] = 4'(i - 4); end
            if (c[14:13] == 2'd0 && c[12:9] == 4'hF) c[9] = 1'b0;
            wr(3'd0, c); wr(3'd1, o); wr(3'd2, pl); wr(3'd3, ph);
            wr(3'd4, {7'($urandom), 1'($urandom), 7'($urandom), 1'b0});
            repeat (5) @(negedge clk);
            if (c[14:13] != 2'd0) begin
                chk_regs("R6", exp_fail(c), 16'h0, 16'hFFFF, 16'hFFFF, 1'b1);
                rd(3'd4, v); chk("R3 busy", v, 16'h0011);
                wr(3'd4, 16'h0001);
                chk("R4 keep", {15'd0, irq_o}, 16'd1);
                wr(3'd4, 16'h0101);
                chk("R4 clear", {15'd0, irq_o}, 16'd0);
                rd(3'd4, v); chk("R3 free", v, 16'h0111);
            end else begin
                chk_regs("R7", c, o, pl, ph, 1'b0);
            end
        end

        // R8 startup
        wr(3'd0, 16'h1E00);
        wr(3'd4, 16'h0000);
        wait_irq(10, t_boot, ok);
        chk("R8 irq", {15'd0, ok}, 16'd1);
        chk_regs("R8", 16'h8600, 16'h0, 16'h0, 16'h0C00, 1'b1);
        wr(3'd4, 16'h0101);

        // R9 first and steady peek intervals
        wait_irq(P + 20, t1, ok);
        chk("R9 first", 16'(t1 - t_boot), 16'(P + 2));
        chk_regs("R9", exp_peek(), PADDR[15:0], 16'h0, 16'h0, 1'b1);
        wr(3'd4, 16'h0101);
        wait_irq(P + 20, t2, ok);
        chk("R9 period", 16'(t2 - t1), 16'(P));

        // R10 skipped periods under pending interrupt
        repeat (2 * P + 10) @(negedge clk);
        chk("R10 pending", {15'd0, irq_o}, 16'd1);
        wr(3'd4, 16'h0101);
        wait_irq(P + 20, t3, ok);
        chk("R10 grid", 16'(t3 - t2), 16'(3 * P));

        // R11 reply held behind pending peek
        wr(3'd0, 16'h2A55);
        wr(3'd4, 16'h0000);
        repeat (5) @(negedge clk);
        chk_regs("R11 held", 16'h2A55, PADDR[15:0], 16'h0, 16'h0, 1'b1);
        wr(3'd4, 16'h0101);
        repeat (5) @(negedge clk);
        chk_regs("R11 released", 16'h2EFF, 16'h0, 16'hFFFF, 16'hFFFF, 1'b1);
        wr(3'd4, 16'h0101);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule